// File: doc/BRIEF.md
# Pad Drive Compensation Selector and Calibrator

This block sits between the analog drive-strength estimator of an I/O pad group and the pads themselves. The estimator supplies two calculated codes for the group: a 6-bit code for the falling edge and a 5-bit code for the rising edge. Software supplies a programmable code and a 2-bit mode for each edge. The mode chooses what the pads receive:
- the calculated code;
- the programmable code;
- the sum of the two, clamped at the all-ones value of that edge's width;
- the calculated code minus the programmable code, floored at zero.

The codes driven to the pads are held in registers. They change only during a calibration cycle, and never because an input moved. A calibration cycle raises a bus request and waits for the grant. It loads the freshly selected codes in the cycle after the grant and drops the request one cycle later. The first calibration follows reset release after a fixed delay and happens whether or not periodic calibration is enabled. Later calibrations recur at a programmable interval while they are enabled. A second pad group, whose signals are not clock forwarded, captures the codes of the first calibration after reset and keeps them until the next reset.

Top module: `pad_comp_cal`

## Requirements
- R1: With mode 00 (`mode_*_i` = 2'b00) an update loads the calculated code of that edge unchanged.
- R2: With mode 01 an update loads the programmable code of that edge unchanged.
- R3: With mode 10 an update loads calculated plus programmable, clamped at 3Fh for the falling code and at 1Fh for the rising code.
- R4: With mode 11 an update loads calculated minus programmable, or zero when the programmable code is larger.
- R5: `fall_code_o` and `rise_code_o` change only at the clock edge that ends the update cycle. The code, mode and calculated inputs are sampled only at that edge, and changing them at any other time has no effect on the outputs.
- R6: `bus_req_o` stays high until `bus_gnt_i` is seen high at a clock edge. The next cycle is the update cycle, with the request still high. The request is low in the cycle after that.
- R7: After reset release, `bus_req_o` first rises at the FIRST_DLY-th rising clock edge, independent of `cal_en_i`.
- R8: After a calibration, no new request is raised while `cal_en_i` is low. While it is high, the request rises `cal_period_i` edges after it dropped, and a period of 0 acts as 1.
- R9: `fixed_fall_o` and `fixed_rise_o` take the selected codes at the first update after reset and then hold through all later updates.
- R10: While reset is asserted, all code outputs and `bus_req_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cal_en_i | input | 1 | Enables periodic calibration cycles |
| cal_period_i | input | PERIOD_W | Cycles between the end of one calibration and the next request |
| calc_fall_i | input | FALL_W | Calculated falling-edge code |
| calc_rise_i | input | RISE_W | Calculated rising-edge code |
| prog_fall_i | input | FALL_W | Programmable falling-edge code |
| prog_rise_i | input | RISE_W | Programmable rising-edge code |
| mode_fall_i | input | 2 | Falling-edge mode: 00 calc, 01 prog, 10 sum, 11 diff |
| mode_rise_i | input | 2 | Rising-edge mode, same encoding |
| bus_gnt_i | input | 1 | Bus grant for the calibration cycle |
| bus_req_o | output | 1 | Bus request for the calibration cycle |
| fall_code_o | output | FALL_W | Applied falling-edge code, forwarded group |
| rise_code_o | output | RISE_W | Applied rising-edge code, forwarded group |
| fixed_fall_o | output | FALL_W | Falling-edge code of the non-forwarded group |
| fixed_rise_o | output | RISE_W | Rising-edge code of the non-forwarded group |

## Verification
The request is due at the FIRST_DLY-th edge after reset release. After that it is due a full period after each drop. The codes are due one edge after the edge that saw the grant, and the request falls at that same edge. The bench drives inputs on the falling clock edge and compares its cycle model against every output on the next falling edge. Each comparison therefore lands half a cycle after the edge on which a result is due. Directed checks count falling edges from reset release, and from the drop of the request, to confirm the delays. Other directed checks read the codes two cycles after the grant and again after inputs change between calibrations.

// File: rtl/pad_comp_pkg.sv
package pad_comp_pkg;
  typedef enum logic [1:0] {
    MODE_CALC = 2'b00,
    MODE_PROG = 2'b01,
    MODE_SUM  = 2'b10,
    MODE_DIFF = 2'b11
  } comp_mode_e;

  typedef enum logic [1:0] {
    ST_FIRST  = 2'd0,
    ST_REQ    = 2'd1,
    ST_UPD    = 2'd2,
    ST_PERIOD = 2'd3
  } cal_st_e;
endpackage

// File: rtl/comp_mode_sel.sv
module comp_mode_sel
  import pad_comp_pkg::*;
#(
  parameter int W = 6
) (
  input  logic [W-1:0] calc_i,
  input  logic [W-1:0] prog_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] code_o
);
  localparam logic [W-1:0] MAX_CODE = {W{1'b1}};

  logic [W:0]   sum_w;
  logic [W-1:0] sum_sat;
  logic [W-1:0] diff_flr;
  comp_mode_e   mode;

  assign mode     = comp_mode_e'(mode_i);
  assign sum_w    = {1'b0, calc_i} + {1'b0, prog_i};
  assign sum_sat  = sum_w[W] ? MAX_CODE : sum_w[W-1:0];
  assign diff_flr = (calc_i > prog_i) ? (calc_i - prog_i) : '0;

  always_comb begin
    unique case (mode)
      MODE_CALC: code_o = calc_i;
      MODE_PROG: code_o = prog_i;
      MODE_SUM:  code_o = sum_sat;
      default:   code_o = diff_flr;
    endcase
  end
endmodule

// File: rtl/cal_sched.sv
module cal_sched
  import pad_comp_pkg::*;
#(
  parameter int FIRST_DLY = 264000,
  parameter int PERIOD_W  = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cal_en_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                gnt_i,
  output logic                req_o,
  output logic                upd_o
);
  localparam int FD_W  = $clog2(FIRST_DLY + 1);
  localparam int CNT_W = (FD_W > PERIOD_W) ? FD_W : PERIOD_W;
  localparam logic [CNT_W-1:0] FIRST_LIM = CNT_W'(FIRST_DLY - 1);

  cal_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   per_ext;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign per_ext = (CNT_W + 1)'(period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FIRST;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_FIRST: begin
          if (cnt_q == FIRST_LIM) begin
            st_q  <= ST_REQ;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
          end
        end
        ST_REQ: if (gnt_i) st_q <= ST_UPD;
        ST_UPD: begin
          st_q  <= ST_PERIOD;
          cnt_q <= '0;
        end
        default: begin
          if (!cal_en_i) begin
            cnt_q <= '0;
          end else if (cnt_inc >= per_ext) begin  // period 0 behaves as 1
            st_q  <= ST_REQ;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
          end
        end
      endcase
    end
  end

  assign req_o = (st_q == ST_REQ) || (st_q == ST_UPD);
  assign upd_o = (st_q == ST_UPD);
endmodule

// File: rtl/pad_comp_cal.sv
module pad_comp_cal #(
  parameter int FALL_W    = 6,
  parameter int RISE_W    = 5,
  parameter int FIRST_DLY = 264000,
  parameter int PERIOD_W  = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cal_en_i,
  input  logic [PERIOD_W-1:0] cal_period_i,
  input  logic [FALL_W-1:0]   calc_fall_i,
  input  logic [RISE_W-1:0]   calc_rise_i,
  input  logic [FALL_W-1:0]   prog_fall_i,
  input  logic [RISE_W-1:0]   prog_rise_i,
  input  logic [1:0]          mode_fall_i,
  input  logic [1:0]          mode_rise_i,
  input  logic                bus_gnt_i,
  output logic                bus_req_o,
  output logic [FALL_W-1:0]   fall_code_o,
  output logic [RISE_W-1:0]   rise_code_o,
  output logic [FALL_W-1:0]   fixed_fall_o,
  output logic [RISE_W-1:0]   fixed_rise_o
);
  logic              upd;
  logic              fixed_vld_q;
  logic [FALL_W-1:0] sel_fall;
  logic [RISE_W-1:0] sel_rise;
  logic [FALL_W-1:0] fall_q, fixed_fall_q;
  logic [RISE_W-1:0] rise_q, fixed_rise_q;

  comp_mode_sel #(.W(FALL_W)) u_sel_fall (
    .calc_i (calc_fall_i),
    .prog_i (prog_fall_i),
    .mode_i (mode_fall_i),
    .code_o (sel_fall)
  );

  comp_mode_sel #(.W(RISE_W)) u_sel_rise (
    .calc_i (calc_rise_i),
    .prog_i (prog_rise_i),
    .mode_i (mode_rise_i),
    .code_o (sel_rise)
  );

  cal_sched #(.FIRST_DLY(FIRST_DLY), .PERIOD_W(PERIOD_W)) u_sched (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cal_en_i (cal_en_i),
    .period_i (cal_period_i),
    .gnt_i    (bus_gnt_i),
    .req_o    (bus_req_o),
    .upd_o    (upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_q       <= '0;
      rise_q       <= '0;
      fixed_fall_q <= '0;
      fixed_rise_q <= '0;
      fixed_vld_q  <= 1'b0;
    end else if (upd) begin
      fall_q <= sel_fall;
      rise_q <= sel_rise;
      if (!fixed_vld_q) begin
        fixed_fall_q <= sel_fall;
        fixed_rise_q <= sel_rise;
        fixed_vld_q  <= 1'b1;
      end
    end
  end

  assign fall_code_o  = fall_q;
  assign rise_code_o  = rise_q;
  assign fixed_fall_o = fixed_fall_q;
  assign fixed_rise_o = fixed_rise_q;
endmodule

// File: rtl/pad_comp_cal_chk.sv
module pad_comp_cal_chk #(
  parameter int FALL_W = 6,
  parameter int RISE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_gnt_i,
  input logic              bus_req_o,
  input logic              upd,
  input logic              fixed_vld_q,
  input logic [FALL_W-1:0] fall_code_o,
  input logic [RISE_W-1:0] rise_code_o,
  input logic [FALL_W-1:0] fixed_fall_o,
  input logic [RISE_W-1:0] fixed_rise_o
);
  a_r5_codes_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(upd) |-> ($stable(fall_code_o) && $stable(rise_code_o)));

  a_r6_req_waits_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i && !upd) |=> bus_req_o);

  a_r6_gnt_to_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && !upd) |=> (upd && bus_req_o));

  a_r6_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> !bus_req_o);

  a_r9_fixed_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fixed_vld_q) |-> ($stable(fixed_fall_o) && $stable(fixed_rise_o)));

  a_r10_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (fall_code_o == '0 && rise_code_o == '0 && !bus_req_o
                 && fixed_fall_o == '0 && fixed_rise_o == '0));
endmodule

bind pad_comp_cal pad_comp_cal_chk #(.FALL_W(FALL_W), .RISE_W(RISE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_gnt_i    (bus_gnt_i),
  .bus_req_o    (bus_req_o),
  .upd          (upd),
  .fixed_vld_q  (fixed_vld_q),
  .fall_code_o  (fall_code_o),
  .rise_code_o  (rise_code_o),
  .fixed_fall_o (fixed_fall_o),
  .fixed_rise_o (fixed_rise_o)
);

// File: tb/pad_comp_cal_bench.sv
module pad_comp_cal_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FALL_W     = 6;
  localparam int RISE_W     = 5;
  localparam int FIRST_DLY  = 20;
  localparam int PERIOD_W   = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cal_en = 1'b0;
  logic [PERIOD_W-1:0] period = '0;
  logic [FALL_W-1:0] calc_fall = '0, prog_fall = '0;
  logic [RISE_W-1:0] calc_rise = '0, prog_rise = '0;
  logic [1:0] mode_fall = 2'b00, mode_rise = 2'b00;
  logic gnt = 1'b0;
  logic req;
  logic [FALL_W-1:0] fall_code, fixed_fall;
  logic [RISE_W-1:0] rise_code, fixed_rise;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_comp_cal #(.FALL_W(FALL_W), .RISE_W(RISE_W), .FIRST_DLY(FIRST_DLY),
                 .PERIOD_W(PERIOD_W)) u_pad_comp_cal (
    .clk_i(clk), .rst_ni(rst_ni), .cal_en_i(cal_en), .cal_period_i(period),
    .calc_fall_i(calc_fall), .calc_rise_i(calc_rise),
    .prog_fall_i(prog_fall), .prog_rise_i(prog_rise),
    .mode_fall_i(mode_fall), .mode_rise_i(mode_rise),
    .bus_gnt_i(gnt), .bus_req_o(req),
    .fall_code_o(fall_code), .rise_code_o(rise_code),
    .fixed_fall_o(fixed_fall), .fixed_rise_o(fixed_rise)
  );

  // reference: 0 first wait, 1 request, 2 update, 3 period wait
  int m_st, m_cnt, m_fall, m_rise, m_ffall, m_frise;
  bit m_fixed;

  function automatic int pick(int c, int p, int m, int mx);
    case (m)
      0: return c;
      1: return p;
      2: return (c + p > mx) ? mx : c + p;
      default: return (c > p) ? c - p : 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_fall = 0; m_rise = 0;
      m_ffall = 0; m_frise = 0; m_fixed = 0;
    end else begin
      case (m_st)
        0: if (m_cnt == FIRST_DLY - 1) begin m_st = 1; m_cnt = 0; end
           else m_cnt++;
        1: if (gnt) m_st = 2;
        2: begin
          m_fall = pick(calc_fall, prog_fall, mode_fall, 63);
          m_rise = pick(calc_rise, prog_rise, mode_rise, 31);
          if (!m_fixed) begin m_ffall = m_fall; m_frise = m_rise; m_fixed = 1; end
          m_st = 3; m_cnt = 0;
        end
        default: begin
          if (!cal_en) m_cnt = 0;
          else if (m_cnt + 1 >= int'(period)) begin m_st = 1; m_cnt = 0; end
          else m_cnt++;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req_tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(req == (m_st == 1 || m_st == 2), "R6 req", req, (m_st == 1 || m_st == 2));
      chk(fall_code == m_fall, "R5 fall", fall_code, m_fall);
      chk(rise_code == m_rise, "R5 rise", rise_code, m_rise);
      chk(fixed_fall == m_ffall, "R9 fixed fall", fixed_fall, m_ffall);
      chk(fixed_rise == m_frise, "R9 fixed rise", fixed_rise, m_frise);
    end
  end

  task automatic wait_req(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!req && n < 5000);
  endtask

  task automatic do_cal(input int dly);
    int n;
    wait_req(n);
    repeat (dly) @(negedge clk);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_in(input int cf, input int pf, input int mf,
                        input int cr, input int pr, input int mr);
    calc_fall = FALL_W'(cf); prog_fall = FALL_W'(pf); mode_fall = 2'(mf);
    calc_rise = RISE_W'(cr); prog_rise = RISE_W'(pr); mode_rise = 2'(mr);
  endtask

  task automatic chk_codes(input string tag, input int ef, input int er);
    chk(fall_code == FALL_W'(ef), tag, fall_code, ef);
    chk(rise_code == RISE_W'(er), tag, rise_code, er);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!req && fall_code == 0 && rise_code == 0 && fixed_fall == 0 && fixed_rise == 0,
        "R10 reset", {req, fall_code, rise_code}, 0);
    set_in('h15, 'h07, 0, 'h0A, 'h03, 0);
    rst_ni = 1'b1;
    // R7: first request at the FIRST_DLY-th edge, enable low
    wait_req(n);
    chk(n == FIRST_DLY, "R7 first delay", n, FIRST_DLY);
    // R6: request held while grant withheld
    repeat (4) @(negedge clk);
    chk(req == 1'b1, "R6 held", req, 1);
    gnt = 1'b1; @(negedge clk); gnt = 1'b0;
    chk(req == 1'b1, "R6 update cycle", req, 1);
    @(negedge clk);
    chk(req == 1'b0, "R6 drop", req, 0);
    chk_codes("R1 calc", 'h15, 'h0A);
    chk(fixed_fall == 'h15 && fixed_rise == 'h0A, "R9 first load", fixed_fall, 'h15);
    // R5: inputs change between calibrations, outputs hold
    set_in('h2F, 'h01, 1, 'h11, 'h02, 1);
    repeat (30) @(negedge clk);
    chk_codes("R5 hold", 'h15, 'h0A);
    chk(req == 1'b0, "R8 disabled", req, 0);
    // R8: periodic, measured from drop
    period = 8'd10; cal_en = 1'b1;
    do_cal(2);
    chk_codes("R2 prog", 'h01, 'h02);
    wait_req(n);
    chk(n == 10, "R8 period", n, 10);
    set_in('h3A, 'h10, 2, 'h1C, 'h08, 2);
    gnt = 1'b1; @(negedge clk); gnt = 1'b0; @(negedge clk);
    chk_codes("R3 saturate", 'h3F, 'h1F);
    set_in('h12, 'h0C, 2, 'h07, 'h05, 2);
    do_cal(0);
    chk_codes("R3 sum", 'h1E, 'h0C);
    set_in('h05, 'h09, 3, 'h14, 'h03, 3);
    do_cal(1);
    chk_codes("R4 floor", 'h00, 'h11);
    set_in('h20, 'h03, 3, 'h1F, 'h1F, 2);
    do_cal(3);
    chk_codes("R4 diff mixed", 'h1D, 'h1F);
    chk(fixed_fall == 'h15 && fixed_rise == 'h0A, "R9 held", fixed_fall, 'h15);
    // R8: period 0 acts as 1
    period = 8'd0;
    wait_req(n);
    gnt = 1'b1; @(negedge clk); gnt = 1'b0; @(negedge clk);
    wait_req(n);
    chk(n == 1, "R8 period zero", n, 1);
    cal_en = 1'b0;
    gnt = 1'b1; @(negedge clk); gnt = 1'b0; @(negedge clk);
    repeat (40) @(negedge clk);
    chk(req == 1'b0, "R8 disable stops", req, 0);
    // R10 + R9: reset clears and fixed group reloads
    rst_ni = 1'b0; #1;
    chk(fixed_fall == 0 && fall_code == 0 && !req, "R10 warm reset", fixed_fall, 0);
    set_in('h09, 'h01, 0, 'h04, 'h01, 0);
    @(negedge clk); rst_ni = 1'b1;
    do_cal(0);
    chk(fixed_fall == 'h09 && fixed_rise == 'h04, "R9 reload", fixed_fall, 'h09);
    repeat (5) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule